// File: doc/BRIEF.md
# Burst Refresh Scheduler

This block keeps a row-organised DRAM alive by stopping the CPU at a fixed rate and refreshing a run of rows back to back while the CPU is stopped. No refresh cycle is mixed into opcode fetches, so the fetch sequencer can keep the upper address byte of the open row latched between fetches. Once every refresh interval (30 us by default) the block raises a halt request. It waits for the fetch sequencer to acknowledge that its bus access has ended. It then issues a fixed number of refresh strobes, each carrying a row address. The halt is held for at least the window time (4 us by default). When the halt is released, a one-cycle pulse tells the fetch sequencer that its latched open row is no longer valid.

The interval and the window are given in nanoseconds. They are converted to cycles of the system clock, whose rate is a parameter in kHz. At 7.159 MHz this gives 215 and 29 cycles. The refresh row counter is 8 bits wide. It carries over from one window to the next, so the whole array is covered after 256 strobes.

Top module: `refresh_burst_sched`

## Requirements
- R1: After reset, halt_req_o, refresh_o and open_row_inval_o are low and refresh_row_o is 0.
- R2: A window opens with halt_req_o rising, first in the cycle reached after PERIOD_CYC clocks from reset release and then every PERIOD_CYC cycles (215 by default), timed from the opening of the previous window.
- R3: refresh_o stays low while halt_req_o is low, and stays low within a window until halt_ack_i has been sampled high.
- R4: Each window issues exactly ROWS_PER_BURST strobes on refresh_o (8 by default). Each strobe is one cycle long and strobes are SLOT_CYC cycles apart (3 by default). The first strobe comes in the cycle after halt_ack_i is sampled high.
- R5: During each strobe refresh_row_o shows the row being refreshed. It then advances by one, wraps from 255 to 0, and is not reset between windows.
- R6: halt_req_o stays high for max(WIN_CYC, d + ROWS_PER_BURST*SLOT_CYC + 2) cycles, where d is the number of halt cycles before halt_ack_i is sampled high. The default WIN_CYC is 29.
- R7: A late acknowledge does not move later windows. They still open on the PERIOD_CYC grid set by the first window.
- R8: open_row_inval_o is high for exactly one cycle, the first cycle after halt_req_o falls, and is low at all other times.
- R9: If the period expires while a window is still open, the next window opens one cycle after the current one closes, and the grid is kept for the windows after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_ack_i | input | 1 | Fetch sequencer reports that the bus is idle and the CPU is halted |
| halt_req_o | output | 1 | CPU halt request, high for the whole refresh window |
| refresh_o | output | 1 | One-cycle refresh strobe for the row on refresh_row_o |
| refresh_row_o | output | ROW_W | Row address to refresh |
| open_row_inval_o | output | 1 | One-cycle pulse that drops the fetch sequencer's latched open row |

## Verification
The hard case is the expiry of the period while a window is still open. This happens because the acknowledge is held back far beyond one period. The bench withholds halt_ack_i for 230 cycles, so the window is still open when the next period boundary arrives. It then checks that halt_req_o is low for exactly one cycle, that the invalidate pulse falls in that cycle, and that the deferred window starts at once with the next row number. The window after that must rise on the original grid again.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_BURST,
    ST_HOLD
  } win_st_e;

  function automatic int ns_to_cyc(input int khz, input int ns);
    return (khz * ns + 500000) / 1000000;
  endfunction

endpackage

// File: rtl/rfsh_period_timer.sv
module rfsh_period_timer #(
  parameter int PERIOD_CYC = 215,
  localparam int CNT_W = $clog2(PERIOD_CYC)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == CNT_W'(PERIOD_CYC - 1));
  assign tick_o = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/rfsh_win_ctrl.sv
module rfsh_win_ctrl
  import rfsh_pkg::*;
#(
  parameter int WIN_CYC  = 29,
  parameter int ROWS     = 8,
  parameter int SLOT_CYC = 3,
  localparam int WW = $clog2(WIN_CYC + 1),
  localparam int SW = $clog2(SLOT_CYC + 1),
  localparam int BW = $clog2(ROWS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ack_i,
  output logic halt_o,
  output logic slot_o,
  output logic inval_o
);

  win_st_e       state_q, state_d;
  logic [WW-1:0] win_q;
  logic [SW-1:0] slot_q;
  logic [BW-1:0] burst_q;
  logic          pend_q;
  logic          inval_q;
  logic          win_done, slot_last, burst_last, leave;

  assign win_done   = (win_q >= WW'(WIN_CYC - 1));
  assign slot_last  = (slot_q == SW'(SLOT_CYC - 1));
  assign burst_last = (burst_q == BW'(ROWS - 1));

  always_comb begin
    state_d = state_q;
    leave   = 1'b0;
    case (state_q)
      ST_IDLE:  if (start_i || pend_q) state_d = ST_WAIT;
      ST_WAIT:  if (ack_i) state_d = ST_BURST;
      ST_BURST: if (slot_last && burst_last) state_d = ST_HOLD;
      ST_HOLD: begin
        if (win_done) begin
          state_d = ST_IDLE;
          leave   = 1'b1;
        end
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      inval_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      inval_q <= leave;
      // a period that expires inside an open window is deferred, not dropped
      if (state_q == ST_IDLE) pend_q <= 1'b0;
      else if (start_i)       pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                win_q <= '0;
    else if (state_q == ST_IDLE) win_q <= '0;
    else if (!win_done)         win_q <= win_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      burst_q <= '0;
    end else if (state_q != ST_BURST) begin
      slot_q  <= '0;
      burst_q <= '0;
    end else if (slot_last) begin
      slot_q  <= '0;
      burst_q <= burst_q + 1'b1;
    end else begin
      slot_q  <= slot_q + 1'b1;
    end
  end

  assign halt_o  = (state_q != ST_IDLE);
  assign slot_o  = (state_q == ST_BURST) && (slot_q == '0);
  assign inval_o = inval_q;

endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int ROW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [ROW_W-1:0] row_o
);

  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_q <= '0;
    else if (inc_i) row_q <= row_q + 1'b1;
  end

  assign row_o = row_q;

endmodule

// File: rtl/refresh_burst_sched.sv
module refresh_burst_sched
  import rfsh_pkg::*;
#(
  parameter int CLK_KHZ        = 7159,
  parameter int PERIOD_NS      = 30000,
  parameter int WINDOW_NS      = 4000,
  parameter int ROW_W          = 8,
  parameter int ROWS_PER_BURST = 8,
  parameter int SLOT_CYC       = 3,
  localparam int PERIOD_CYC = ns_to_cyc(CLK_KHZ, PERIOD_NS),
  localparam int WIN_CYC    = ns_to_cyc(CLK_KHZ, WINDOW_NS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_ack_i,
  output logic             halt_req_o,
  output logic             refresh_o,
  output logic [ROW_W-1:0] refresh_row_o,
  output logic             open_row_inval_o
);

  logic tick;
  logic slot;

  rfsh_period_timer #(
    .PERIOD_CYC(PERIOD_CYC)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  rfsh_win_ctrl #(
    .WIN_CYC (WIN_CYC),
    .ROWS    (ROWS_PER_BURST),
    .SLOT_CYC(SLOT_CYC)
  ) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tick),
    .ack_i  (halt_ack_i),
    .halt_o (halt_req_o),
    .slot_o (slot),
    .inval_o(open_row_inval_o)
  );

  rfsh_row_ctr #(
    .ROW_W(ROW_W)
  ) u_row (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (slot),
    .row_o (refresh_row_o)
  );

  assign refresh_o = slot;

endmodule

// File: rtl/refresh_burst_sched_chk.sv
module refresh_burst_sched_chk #(
  parameter int ROW_W   = 8,
  parameter int WIN_CYC = 29
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             halt_req_o,
  input logic             refresh_o,
  input logic [ROW_W-1:0] refresh_row_o,
  input logic             open_row_inval_o
);

  logic [15:0] hlen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      hlen_q <= '0;
    else if (!halt_req_o)             hlen_q <= '0;
    else if (hlen_q != 16'hffff)      hlen_q <= hlen_q + 1'b1;
  end

  // R3
  no_idle_refresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |-> halt_req_o);

  // R4
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |=> !refresh_o);

  // R5
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |=> (refresh_row_o == $past(refresh_row_o) + ROW_W'(1)));

  // R5
  row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !refresh_o |=> $stable(refresh_row_o));

  // R6
  min_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halt_req_o) |-> (hlen_q >= 16'(WIN_CYC)));

  // R8
  inval_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halt_req_o) |-> open_row_inval_o);

  // R8
  inval_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_row_inval_o |-> (!halt_req_o && $past(halt_req_o)));

endmodule

bind refresh_burst_sched refresh_burst_sched_chk #(
  .ROW_W  (ROW_W),
  .WIN_CYC(WIN_CYC)
) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .halt_req_o      (halt_req_o),
  .refresh_o       (refresh_o),
  .refresh_row_o   (refresh_row_o),
  .open_row_inval_o(open_row_inval_o)
);

// File: tb/refresh_burst_sched_tb_top.sv
`timescale 1ns/1ps
module refresh_burst_sched_tb_top;

  localparam int PERIOD = 215;
  localparam int WIN    = 29;
  localparam int ROWS   = 8;
  localparam int SLOT   = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ack = 1'b0;
  logic       halt, ref_s, inval;
  logic [7:0] row;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int exp_row = 0;
  bit wrapped = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  refresh_burst_sched dut_i (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .halt_ack_i      (ack),
    .halt_req_o      (halt),
    .refresh_o       (ref_s),
    .refresh_row_o   (row),
    .open_row_inval_o(inval)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // waits for the next window, acks after d halt cycles, checks the window; returns its rise cycle
  task automatic run_window(input int d, output int rise);
    int  hlen = 0, n = 0, last = -1, exp_len;
    bit  quiet = 1'b1;
    while (!halt) begin
      if (ref_s || inval) quiet = 1'b0;
      @(negedge clk);
    end
    chk(quiet, "R3", "strobe or inval outside window", int'(ref_s | inval), 0);
    rise = cyc;
    while (halt) begin
      if (hlen == d) ack = 1'b1;
      if (ref_s) begin
        if (n == 0) chk(hlen == d + 1, "R4", "first strobe offset", hlen, d + 1);
        else        chk(hlen - last == SLOT, "R4", "strobe spacing", hlen - last, SLOT);
        chk(int'(row) == exp_row, "R5", "row value", int'(row), exp_row);
        if (exp_row == 255) wrapped = 1'b1;
        exp_row = (exp_row + 1) % 256;
        n++;
        last = hlen;
      end
      hlen++;
      @(negedge clk);
    end
    ack = 1'b0;
    exp_len = (d + ROWS * SLOT + 2 > WIN) ? d + ROWS * SLOT + 2 : WIN;
    chk(n == ROWS, "R4", "strobes per window", n, ROWS);
    chk(hlen == exp_len, "R6", "halt length", hlen, exp_len);
    chk(inval == 1'b1, "R8", "inval after fall", int'(inval), 1);
    @(negedge clk);
    chk(inval == 1'b0, "R8", "inval width", int'(inval), 0);
  endtask

  task automatic t_reset();
    chk(!halt && !ref_s && !inval, "R1", "control outputs in reset", int'({halt, ref_s, inval}), 0);
    chk(row == 8'd0, "R1", "row in reset", int'(row), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!halt && !ref_s && !inval, "R1", "control outputs after release", int'({halt, ref_s, inval}), 0);
  endtask

  task automatic t_grid_and_late_ack(output int base);
    int r;
    run_window(0, r);
    chk(r == PERIOD, "R2", "first window rise", r, PERIOD);
    base = r;
    run_window(1, r);
    chk(r == base + PERIOD, "R2", "second window rise", r, base + PERIOD);
    run_window(10, r);
    chk(r == base + 2 * PERIOD, "R2", "late-ack window rise", r, base + 2 * PERIOD);
    run_window(0, r);
    chk(r == base + 3 * PERIOD, "R7", "rise after late ack", r, base + 3 * PERIOD);
  endtask

  task automatic t_overrun(input int base);
    int r, r2;
    run_window(230, r);
    chk(r == base + 4 * PERIOD, "R2", "overrun window rise", r, base + 4 * PERIOD);
    // run_window's last negedge is the first one after the invalidate cycle
    chk(halt == 1'b1, "R9", "deferred window restarts", int'(halt), 1);
    run_window(0, r2);
    chk(r2 == r + 230 + ROWS * SLOT + 2 + 1, "R9", "deferred window rise", r2, r + 230 + ROWS * SLOT + 3);
    run_window(0, r2);
    chk(r2 == base + 6 * PERIOD, "R9", "grid kept after deferral", r2, base + 6 * PERIOD);
  endtask

  task automatic t_wrap(input int base);
    int r = 0;
    for (int k = 0; k < 27; k++) run_window(k % 3, r);
    chk(r == base + 33 * PERIOD, "R7", "grid after many windows", r, base + 33 * PERIOD);
    chk(wrapped, "R5", "row wrapped 255 to 0", int'(wrapped), 1);
  endtask

  initial begin
    int base;
    t_reset();
    t_grid_and_late_ack(base);
    t_overrun(base);
    t_wrap(base);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule